// File: doc/BRIEF.md
# Dual-Channel GPIO with Change Interrupt

A register-mapped general-purpose I/O block with one or two independent channels. Each channel owns an output value register and a direction register. A direction bit of 1 makes the pin an input and turns its output enable off. A bit of 0 drives the stored output value onto the pin. Pin inputs pass through a two-flop synchronizer. Reading a channel's data register returns the synchronized pin for input bits and the stored output value for output bits.

Each channel raises a sticky status bit whenever its synchronized input value changes. Software clears these bits by writing ones back to them. One interrupt line combines the status bits through a per-channel enable register and a single global enable bit. Software reaches all of this over a plain 32-bit bus made of a byte address, a write strobe, write data, and a read data port that decodes the current address combinationally. Two parameters set the channel widths, and a third decides whether the second channel is built.

Top module: `gpio_dual`

## Requirements
- R1: After reset both direction registers read all ones, the output values are zero, every output enable is low, and the status, per-channel enable and global enable registers read zero, so the interrupt output is low.
- R2: A write to byte offset 0x0 (channel 1) or 0x8 (channel 2) stores the output value, which appears on that channel's output pins after the write edge. A write to 0x4 or 0xC stores the direction, and each output enable bit is the inverse of its direction bit.
- R3: A read of 0x0 or 0x8 returns, bit by bit, the synchronized pin input where the direction bit is 1 and the stored output value where it is 0. A pin change becomes visible after the second rising clock edge. A read of 0x4 or 0xC returns the direction register.
- R4: Any change of a channel's synchronized input value sets that channel's status bit, whatever the pin directions. Bit 0 belongs to channel 1 and bit 1 to channel 2, in the register at 0x120. The bit is set at the third rising edge after the pin change, and rising and falling changes both count.
- R5: Writing to 0x120 clears each status bit written as 1 and leaves bits written as 0 unchanged. If a new change arrives on the same edge as a clear, the bit stays set.
- R6: The per-channel enable register at 0x128 uses the status bit positions. The interrupt output is high exactly when the global enable is set and some status bit has its enable bit set.
- R7: The global enable register at 0x11C keeps only bit 31. Writes to its other bits are ignored, and they read back as zero.
- R8: When the second channel is not built, offsets 0x8 and 0xC read zero and ignore writes, status bit 1 never sets, and the channel 2 output pins and output enables stay zero.
- R9: Reads of unmapped offsets return zero, and writes to them change no register.
- R10: A status bit stays set, with no further pin activity, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 9 | Byte address of the register |
| busWe | input | 1 | Write strobe, one write per cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pinIn1 | input | CH1_W | Channel 1 pin inputs (asynchronous) |
| pinOut1 | output | CH1_W | Channel 1 output values |
| pinOe1 | output | CH1_W | Channel 1 output enables, high drives |
| pinIn2 | input | CH2_W | Channel 2 pin inputs (asynchronous) |
| pinOut2 | output | CH2_W | Channel 2 output values |
| pinOe2 | output | CH2_W | Channel 2 output enables, high drives |
| irqOut | output | 1 | Combined interrupt, active high |

## Verification
The assertions assume the bus performs at most one write per cycle with a stable address, and that pins are held low through reset, because the change-detect history resets to zero. The stimulus meets both assumptions. The random and directed sequences drive bus signals and pins just after the falling edge and drop the write strobe after a single rising edge. Reset is applied with all pins at zero. Pins change only at points where the bench has already accounted for the two-cycle synchronizer delay and the third-cycle status update.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;
  localparam int BUS_AW = 9;
  localparam logic [BUS_AW-1:0] OFS_DATA1 = 9'h000;
  localparam logic [BUS_AW-1:0] OFS_DIR1  = 9'h004;
  localparam logic [BUS_AW-1:0] OFS_DATA2 = 9'h008;
  localparam logic [BUS_AW-1:0] OFS_DIR2  = 9'h00C;
  localparam logic [BUS_AW-1:0] OFS_GIE   = 9'h11C;
  localparam logic [BUS_AW-1:0] OFS_STAT  = 9'h120;
  localparam logic [BUS_AW-1:0] OFS_IEN   = 9'h128;
  localparam int GIE_BIT = 31;
  localparam int NUM_CH  = 2;

  typedef enum logic [2:0] {
    RD_NONE, RD_DATA1, RD_DIR1, RD_DATA2, RD_DIR2, RD_GIE, RD_STAT, RD_IEN
  } rdSel_t;

  typedef struct packed {
    logic [NUM_CH-1:0] wrData;
    logic [NUM_CH-1:0] wrDir;
    logic              wrGie;
    logic              wrIen;
    logic              wrClr;
    rdSel_t            rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_dual_ctrl.sv
module gpio_dual_ctrl
  import gpio_dual_pkg::*;
#(
  parameter int HAS_CH2 = 1
) (
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWe,
  output ctrlStrobe_t       strobe
);
  localparam bit CH2_ON = (HAS_CH2 != 0);

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    unique case (busAddr)
      OFS_DATA1: begin strobe.rdSel = RD_DATA1; strobe.wrData[0] = busWe; end
      OFS_DIR1:  begin strobe.rdSel = RD_DIR1;  strobe.wrDir[0]  = busWe; end
      OFS_DATA2: if (CH2_ON) begin strobe.rdSel = RD_DATA2; strobe.wrData[1] = busWe; end
      OFS_DIR2:  if (CH2_ON) begin strobe.rdSel = RD_DIR2;  strobe.wrDir[1]  = busWe; end
      OFS_GIE:   begin strobe.rdSel = RD_GIE;  strobe.wrGie = busWe; end
      OFS_STAT:  begin strobe.rdSel = RD_STAT; strobe.wrClr = busWe; end
      OFS_IEN:   begin strobe.rdSel = RD_IEN;  strobe.wrIen = busWe; end
      default:   strobe.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_dual_slice.sv
module gpio_dual_slice #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrOut,
  input  logic         wrDir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pinIn,
  output logic [W-1:0] pinOut,
  output logic [W-1:0] pinOe,
  output logic [W-1:0] rdData,
  output logic [W-1:0] rdDir,
  output logic         change
);
  logic [W-1:0] outReg, dirReg, syncA, syncB, prevB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg <= '0;
      dirReg <= '1;
      syncA  <= '0;
      syncB  <= '0;
      prevB  <= '0;
    end else begin
      if (wrOut) outReg <= wdata;
      if (wrDir) dirReg <= wdata;
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign change = |(syncB ^ prevB);
  assign rdData = (syncB & dirReg) | (outReg & ~dirReg);
  assign rdDir  = dirReg;
  assign pinOut = outReg;
  assign pinOe  = ~dirReg;

  // R2: output enable follows the last direction write
  p_oe_tracks_dir_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrDir)) |-> (pinOe == ~$past(wdata)));
  // R2: output value only moves on a data write
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(wrOut)) |-> $stable(pinOut));
endmodule

// File: rtl/gpio_dual_datapath.sv
module gpio_dual_datapath
  import gpio_dual_pkg::*;
#(
  parameter int CH1_W   = 32,
  parameter int CH2_W   = 32,
  parameter int HAS_CH2 = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [CH1_W-1:0] pinIn1,
  output logic [CH1_W-1:0] pinOut1,
  output logic [CH1_W-1:0] pinOe1,
  input  logic [CH2_W-1:0] pinIn2,
  output logic [CH2_W-1:0] pinOut2,
  output logic [CH2_W-1:0] pinOe2,
  output logic             irqOut
);
  logic [CH1_W-1:0] rd1, dir1;
  logic [CH2_W-1:0] rd2, dir2;
  logic [NUM_CH-1:0] changeVec, statusReg, ienReg, clrMask;
  logic gieReg;

  gpio_dual_slice #(.W(CH1_W)) u_ch1 (
    .clk(clk), .rstN(rstN), .wrOut(strobe.wrData[0]), .wrDir(strobe.wrDir[0]),
    .wdata(wdata[CH1_W-1:0]), .pinIn(pinIn1), .pinOut(pinOut1), .pinOe(pinOe1),
    .rdData(rd1), .rdDir(dir1), .change(changeVec[0]));

  generate
    if (HAS_CH2 != 0) begin : g_ch2
      gpio_dual_slice #(.W(CH2_W)) u_ch2 (
        .clk(clk), .rstN(rstN), .wrOut(strobe.wrData[1]), .wrDir(strobe.wrDir[1]),
        .wdata(wdata[CH2_W-1:0]), .pinIn(pinIn2), .pinOut(pinOut2), .pinOe(pinOe2),
        .rdData(rd2), .rdDir(dir2), .change(changeVec[1]));
    end else begin : g_no_ch2
      assign pinOut2      = '0;
      assign pinOe2       = '0;
      assign rd2          = '0;
      assign dir2         = '0;
      assign changeVec[1] = 1'b0;
    end
  endgenerate

  assign clrMask = strobe.wrClr ? wdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= '0;
      ienReg    <= '0;
      gieReg    <= 1'b0;
    end else begin
      statusReg <= (statusReg & ~clrMask) | changeVec;
      if (strobe.wrIen) ienReg <= wdata[NUM_CH-1:0];
      if (strobe.wrGie) gieReg <= wdata[GIE_BIT];
    end
  end

  assign irqOut = gieReg & (|(statusReg & ienReg));

  always_comb begin
    unique case (strobe.rdSel)
      RD_DATA1: rdata = 32'(rd1);
      RD_DIR1:  rdata = 32'(dir1);
      RD_DATA2: rdata = 32'(rd2);
      RD_DIR2:  rdata = 32'(dir2);
      RD_GIE:   rdata = {gieReg, 31'd0};
      RD_STAT:  rdata = 32'(statusReg);
      RD_IEN:   rdata = 32'(ienReg);
      default:  rdata = '0;
    endcase
  end

  // R4 and R5: a change always sets the bit, even against a clear
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(changeVec[0])) |-> statusReg[0]);
  // R5: a written one clears a bit with no new change
  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(clrMask[0]) && !$past(changeVec[0])) |-> !statusReg[0]);
  // R10: status holds without a clear
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(statusReg[1]) && !$past(clrMask[1])) |-> statusReg[1]);
  // R6: interrupt needs the global enable and an enabled pending channel
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (gieReg && (statusReg & ienReg) != '0));
  // R8: absent channel never reports
  p_ch2_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_CH2 == 0) |-> (!statusReg[1] && pinOe2 == '0));
endmodule

// File: rtl/gpio_dual.sv
module gpio_dual
  import gpio_dual_pkg::*;
#(
  parameter int CH1_W   = 32,
  parameter int CH2_W   = 32,
  parameter int HAS_CH2 = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [8:0]       busAddr,
  input  logic             busWe,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  input  logic [CH1_W-1:0] pinIn1,
  output logic [CH1_W-1:0] pinOut1,
  output logic [CH1_W-1:0] pinOe1,
  input  logic [CH2_W-1:0] pinIn2,
  output logic [CH2_W-1:0] pinOut2,
  output logic [CH2_W-1:0] pinOe2,
  output logic             irqOut
);
  ctrlStrobe_t strobe;

  gpio_dual_ctrl #(.HAS_CH2(HAS_CH2)) u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .strobe(strobe));

  gpio_dual_datapath #(.CH1_W(CH1_W), .CH2_W(CH2_W), .HAS_CH2(HAS_CH2)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata), .rdata(busRdata),
    .pinIn1(pinIn1), .pinOut1(pinOut1), .pinOe1(pinOe1),
    .pinIn2(pinIn2), .pinOut2(pinOut2), .pinOe2(pinOe2), .irqOut(irqOut));
endmodule

// File: tb/sim_gpio_dual.sv
module sim_gpio_dual;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [8:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] rdata0, rdata1;
  logic [31:0] pinIn1 = '0, pinIn2 = '0, pinInB = '0;
  logic [31:0] pinOut1, pinOe1, pinOut2, pinOe2;
  logic [31:0] bOut1, bOe1, bOut2, bOe2;
  logic irq0, irq1;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_dual u0 (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(rdata0), .pinIn1(pinIn1), .pinOut1(pinOut1),
    .pinOe1(pinOe1), .pinIn2(pinIn2), .pinOut2(pinOut2), .pinOe2(pinOe2), .irqOut(irq0));

  gpio_dual #(.HAS_CH2(0)) u1 (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(rdata1), .pinIn1(pinIn1), .pinOut1(bOut1),
    .pinOe1(bOe1), .pinIn2(pinInB), .pinOut2(bOut2), .pinOe2(bOe2), .irqOut(irq1));

  function automatic logic [31:0] expData(logic [31:0] pin, logic [31:0] outv, logic [31:0] dir);
    return (pin & dir) | (outv & ~dir);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic wr(logic [8:0] a, logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk); @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(logic [8:0] a);
    busAddr = a; #1;
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] o1, d1, p1, o2, d2, p2;
    void'($urandom(32'd1234));
    cycles(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(9'h004); check("R1 dir1", rdata0, 32'hFFFF_FFFF);
    rd(9'h00C); check("R1 dir2", rdata0, 32'hFFFF_FFFF);
    rd(9'h000); check("R1 data1", rdata0, 32'h0);
    rd(9'h120); check("R1 status", rdata0, 32'h0);
    rd(9'h128); check("R1 ien", rdata0, 32'h0);
    rd(9'h11C); check("R1 gie", rdata0, 32'h0);
    check("R1 oe1", pinOe1, 32'h0);
    check("R1 out1", pinOut1, 32'h0);
    check("R1 irq", {31'd0, irq0}, 32'h0);
    @(negedge clk);

    // R2 output and direction
    wr(9'h000, 32'hA5A5_1234);
    wr(9'h004, 32'h0000_FFFF);
    check("R2 out1", pinOut1, 32'hA5A5_1234);
    check("R2 oe1", pinOe1, 32'hFFFF_0000);

    // R3 synchronizer depth and mux
    pinIn1 = 32'h1234_ABCD;
    cycles(1);
    rd(9'h000); check("R3 data1 before sync", rdata0, expData(32'h0, 32'hA5A5_1234, 32'h0000_FFFF));
    cycles(1);
    rd(9'h000); check("R3 data1 after sync", rdata0, expData(32'h1234_ABCD, 32'hA5A5_1234, 32'h0000_FFFF));
    rd(9'h004); check("R3 dir1 read", rdata0, 32'h0000_FFFF);
    cycles(3);

    // R4 status timing, channel 1 then channel 2
    wr(9'h120, 32'h3);
    rd(9'h120); check("R4 status cleared", rdata0, 32'h0);
    pinIn1 = 32'h1234_ABCC;  // falling change on bit 0
    cycles(2);
    rd(9'h120); check("R4 status not yet", rdata0, 32'h0);
    cycles(1);
    rd(9'h120); check("R4 status ch1 set", rdata0, 32'h1);
    pinIn2 = 32'h8000_0000;  // rising change on channel 2
    cycles(3);
    rd(9'h120); check("R4 status ch2 set", rdata0, 32'h3);

    // R10 sticky
    cycles(10);
    rd(9'h120); check("R10 sticky", rdata0, 32'h3);

    // R5 write-one-to-clear, zeros ignored
    wr(9'h120, 32'h0);
    rd(9'h120); check("R5 zero write", rdata0, 32'h3);
    wr(9'h120, 32'h2);
    rd(9'h120); check("R5 clear ch2 only", rdata0, 32'h1);
    // R5 set wins over clear on the same edge
    pinIn1 = 32'h0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(9'h120, 32'h1);
    rd(9'h120); check("R5 set wins", rdata0, 32'h1);
    cycles(2);
    wr(9'h120, 32'h1);
    rd(9'h120); check("R5 clear after", rdata0, 32'h0);

    // R6 and R7 interrupt gating
    pinIn1 = 32'h1;
    cycles(4);
    check("R6 irq no enables", {31'd0, irq0}, 32'h0);
    wr(9'h11C, 32'hFFFF_FFFF);
    rd(9'h11C); check("R7 gie readback", rdata0, 32'h8000_0000);
    check("R6 irq gie only", {31'd0, irq0}, 32'h0);
    wr(9'h128, 32'h2);
    check("R6 irq wrong channel", {31'd0, irq0}, 32'h0);
    wr(9'h128, 32'h1);
    check("R6 irq asserted", {31'd0, irq0}, 32'h1);
    wr(9'h11C, 32'h7FFF_FFFF);
    rd(9'h11C); check("R7 gie low bits ignored", rdata0, 32'h0);
    check("R6 irq gie off", {31'd0, irq0}, 32'h0);
    wr(9'h11C, 32'h8000_0000);
    wr(9'h120, 32'h1);
    check("R6 irq after clear", {31'd0, irq0}, 32'h0);

    // R8 channel 2 present vs absent
    wr(9'h008, 32'hDEAD_BEEF);
    wr(9'h00C, 32'h0F0F_0F0F);
    rd(9'h00C); check("R8 dir2", rdata0, 32'h0F0F_0F0F);
    check("R8 out2", pinOut2, 32'hDEAD_BEEF);
    rd(9'h008); check("R8 absent data2", rdata1, 32'h0);
    rd(9'h00C); check("R8 absent dir2", rdata1, 32'h0);
    check("R8 absent oe2", bOe2, 32'h0);
    check("R8 absent out2", bOut2, 32'h0);
    wr(9'h120, 32'h3);
    pinInB = 32'hFFFF_0000;
    cycles(4);
    rd(9'h120); check("R8 absent status", rdata1, 32'h0);

    // R9 unmapped offsets
    wr(9'h010, 32'hFFFF_FFFF);
    wr(9'h124, 32'hFFFF_FFFF);
    rd(9'h010); check("R9 unmapped read", rdata0, 32'h0);
    rd(9'h124); check("R9 unmapped read 2", rdata0, 32'h0);
    rd(9'h004); check("R9 dir1 unchanged", rdata0, 32'h0000_FFFF);
    rd(9'h128); check("R9 ien unchanged", rdata0, 32'h1);

    // R2 R3 random patterns
    for (int i = 0; i < 150; i++) begin
      o1 = $urandom; d1 = $urandom; p1 = $urandom;
      o2 = $urandom; d2 = $urandom; p2 = $urandom;
      wr(9'h000, o1); wr(9'h004, d1);
      wr(9'h008, o2); wr(9'h00C, d2);
      pinIn1 = p1; pinIn2 = p2;
      cycles(2);
      rd(9'h000); check("R3 random data1", rdata0, expData(p1, o1, d1));
      rd(9'h008); check("R3 random data2", rdata0, expData(p2, o2, d2));
      check("R2 random oe1", pinOe1, ~d1);
      check("R2 random out2", pinOut2, o2);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule